// File: doc/BRIEF.md
# Parallel Display Bus Timing Engine

This block is the master side of an 8080-style parallel bus to a display controller that keeps its own frame memory. Every bus cycle is a sequence of ticks. Chip select, write strobe and read strobe each go low at a programmed tick and return high at another programmed tick. The cycle ends after a programmed number of ticks. A tick lasts either one base clock or two, chosen by a single divider input. A command/data select line and a 16-bit data bus come with the strobes. Narrow (8-bit) and wide (16-bit) transfers are both supported.

A host issues single operations through a valid/ready request port. Each operation is a command write, a parameter/pixel write or a read. The host may hold `req_valid` high for as long as it likes, and a request is taken only in a cycle where `req_ready` is also high. A read captures the input bus at its access tick. It hands the value back on a result port that holds `rd_valid` and `rd_data` steady until `rd_ready` is seen. No new request is accepted while a result is waiting. A streaming mode sends a programmed number of pixels (width times height) taken from a valid/ready pixel input. The pixel source may stall at any time, and `pix_ready` only rises when the bus is free. At the end of the frame the block drops its stream-enable output and gives a one-cycle frame-done pulse.

All timing fields come in on two packed configuration words. A combinational checker tests the ordering rules between the fields. Any violation sets a sticky error flag, and the bus still follows the counts exactly as programmed.

Top module: `pdbus_engine`

## Requirements
- R1: After reset all three strobes are high (inactive), `busy`, `rd_valid`, `strm_active`, `frame_done` and `cfg_err` are 0, and `req_ready` is 1.
- R2: For a write request accepted at a clock edge, tick t (t = 0, 1, ...) is the span of base clocks starting at that edge. `bus_cs_n` is low exactly for cs_on <= t < cs_off and `bus_we_n` is low exactly for we_on <= t < we_off. `bus_re_n` stays high, `busy` is 1, and the cycle lasts max(wr_len, 1) ticks. Field positions: edge word cs_on[3:0], cs_off[9:4], we_on[13:10], we_off[19:14], re_on[23:20], re_off[29:24]; cycle word wr_len[5:0], rd_len[11:6], acc[27:22]. Bits 17:12 of the cycle word have no effect.
- R3: `req_kind` 2'b00 is a command write with `bus_dc` = 0. 2'b01 is a parameter write with `bus_dc` = 1. 2'b1x is a read, and it too has `bus_dc` = 1. During a write `bus_oe` = 1 and `bus_dout` holds the request data. During a read `bus_oe` = 0.
- R4: For a read, `bus_re_n` is low exactly for re_on <= t < re_off, `bus_we_n` stays high, and the cycle lasts max(rd_len, 1) ticks. `bus_din` is captured on the last base clock of tick acc. In the clock after the cycle ends, `rd_valid` is 1 with the captured value.
- R5: With `cfg_div2` = 1 every tick lasts two base clocks. With `cfg_div2` = 0 every tick lasts one.
- R6: With `cfg_width` = 2'b00 (8-bit), `bus_dout[15:8]` and `rd_data[15:8]` are 0. With 2'b11 (16-bit), all 16 bits pass through.
- R7: `req_ready` is 0 while a cycle runs or a read result is pending. `rd_valid` and `rd_data` stay unchanged until a clock where `rd_ready` is 1.
- R8: A `strm_start` pulse with count N > 0 raises `strm_active`. The block then runs exactly N write cycles with `bus_dc` = 1, sending the pixels in order. After the last cycle ends, `strm_active` falls and `frame_done` is high for one clock. With N = 0 it gives `frame_done` at once and never raises `strm_active`.
- R9: While `strm_active` is 1, host requests are refused (`req_ready` = 0) and start no bus cycle.
- R10: `cfg_err` becomes 1 and stays 1 until reset if any of these is broken: we_off > we_on, re_off > re_on, cs_off > cs_on, cs_off >= we_off, cs_off >= re_off, wr_len >= we_off, rd_len >= re_off, acc > re_on, or `cfg_width` is 2'b00 or 2'b11. Strobes still follow the programmed counts.
- R11: `bus_we_n` and `bus_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_edge_word | input | 32 | Packed strobe on/off ticks |
| cfg_cycle_word | input | 32 | Packed cycle lengths and access tick |
| cfg_div2 | input | 1 | 1: tick = two base clocks |
| cfg_width | input | 2 | Bus width select, 00 narrow, 11 wide |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this clock when valid |
| req_kind | input | 2 | 00 command, 01 parameter, 1x read |
| req_data | input | 16 | Write data |
| rd_valid | output | 1 | Read result available |
| rd_ready | input | 1 | Host takes read result |
| rd_data | output | 16 | Read result |
| strm_start | input | 1 | Start a pixel frame |
| strm_count | input | PIX_CNT_W | Pixels in the frame |
| strm_active | output | 1 | Frame in progress |
| frame_done | output | 1 | One-clock end-of-frame pulse |
| pix_valid | input | 1 | Pixel input valid |
| pix_ready | output | 1 | Pixel accepted this clock when valid |
| pix_data | input | 16 | Pixel value |
| busy | output | 1 | A bus cycle is running |
| cfg_err | output | 1 | Sticky configuration error |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | 0 command, 1 data |
| bus_oe | output | 1 | Drive enable for the data bus |
| bus_dout | output | 16 | Outgoing data |
| bus_din | input | 16 | Incoming data |

## Verification
The bench builds the block with PIX_CNT_W = 8. The 6-bit tick fields are swept over small values, so every ordering of strobe edges within a few ticks is covered, in both divider settings and both valid widths. This includes the access tick landing on the last tick of a read. The narrow count width keeps frames of 0 to 4 pixels cheap, so the zero-count frame and the single-pixel frame are both covered. Invalid words are then applied, including zero cycle lengths and the two reserved width codes. These show the error flag sticking while the strobes follow the raw counts.

// File: rtl/pdbus_pkg.sv
package pdbus_pkg;
  localparam int DBUS_W   = 16;
  localparam int NARROW_W = 8;
  localparam int TICK_W   = 6;

  localparam logic [1:0] WIDTH_NARROW = 2'b00;
  localparam logic [1:0] WIDTH_WIDE   = 2'b11;

  // All tick fields widened to one width so comparisons line up.
  typedef struct packed {
    logic [TICK_W-1:0] cs_on;
    logic [TICK_W-1:0] cs_off;
    logic [TICK_W-1:0] we_on;
    logic [TICK_W-1:0] we_off;
    logic [TICK_W-1:0] re_on;
    logic [TICK_W-1:0] re_off;
    logic [TICK_W-1:0] wr_len;
    logic [TICK_W-1:0] rd_len;
    logic [TICK_W-1:0] acc;
  } pdbus_tim_t;
endpackage

// File: rtl/pdbus_cfgchk.sv
module pdbus_cfgchk
  import pdbus_pkg::*;
(
  input  logic [31:0] edge_word,
  input  logic [31:0] cycle_word,
  input  logic [1:0]  width_sel,
  output pdbus_tim_t  tim,
  output logic        wide,
  output logic        bad
);
  logic unused_bits;
  assign unused_bits = ^{edge_word[31:30], cycle_word[31:28], cycle_word[21:12]};

  always_comb begin
    tim.cs_on  = TICK_W'(edge_word[3:0]);
    tim.cs_off = edge_word[9:4];
    tim.we_on  = TICK_W'(edge_word[13:10]);
    tim.we_off = edge_word[19:14];
    tim.re_on  = TICK_W'(edge_word[23:20]);
    tim.re_off = edge_word[29:24];
    tim.wr_len = cycle_word[5:0];
    tim.rd_len = cycle_word[11:6];
    tim.acc    = cycle_word[27:22];
  end

  assign wide = (width_sel == WIDTH_WIDE);

  always_comb begin
    bad = 1'b0;
    if (tim.we_off <= tim.we_on)  bad = 1'b1;
    if (tim.re_off <= tim.re_on)  bad = 1'b1;
    if (tim.cs_off <= tim.cs_on)  bad = 1'b1;
    if (tim.cs_off <  tim.we_off) bad = 1'b1;
    if (tim.cs_off <  tim.re_off) bad = 1'b1;
    if (tim.wr_len <  tim.we_off) bad = 1'b1;
    if (tim.rd_len <  tim.re_off) bad = 1'b1;
    if (tim.acc    <= tim.re_on)  bad = 1'b1;
    if (width_sel != WIDTH_NARROW && width_sel != WIDTH_WIDE) bad = 1'b1;
  end
endmodule

// File: rtl/pdbus_tick.sv
module pdbus_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div2,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= 1'b0;
    else if (run && div2)  phase_q <= ~phase_q;
    else                   phase_q <= 1'b0;
  end

  assign tick = run && (!div2 || phase_q);
endmodule

// File: rtl/pdbus_seq.sv
module pdbus_seq
  import pdbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       launch_rd,
  input  logic       tick,
  input  pdbus_tim_t tim,
  output logic       active,
  output logic       is_rd,
  output logic       last_tick,
  output logic       sample,
  output logic       cs_n,
  output logic       we_n,
  output logic       re_n
);
  logic [TICK_W-1:0] t_q;
  logic [TICK_W-1:0] len;
  logic [TICK_W-1:0] final_t;

  assign len     = is_rd ? tim.rd_len : tim.wr_len;
  assign final_t = (len == '0) ? '0 : len - 1'b1;

  assign last_tick = active && tick && (t_q == final_t);
  assign sample    = active && tick && is_rd && (t_q == tim.acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_rd  <= 1'b0;
      t_q    <= '0;
    end else if (launch) begin
      active <= 1'b1;
      is_rd  <= launch_rd;
      t_q    <= '0;
    end else if (active && tick) begin
      if (t_q == final_t) active <= 1'b0;
      else                t_q    <= t_q + 1'b1;
    end
  end

  logic cs_win, we_win, re_win;
  assign cs_win = (t_q >= tim.cs_on) && (t_q < tim.cs_off);
  assign we_win = (t_q >= tim.we_on) && (t_q < tim.we_off);
  assign re_win = (t_q >= tim.re_on) && (t_q < tim.re_off);

  assign cs_n = !(active && cs_win);
  assign we_n = !(active && !is_rd && we_win);
  assign re_n = !(active &&  is_rd && re_win);
endmodule

// File: rtl/pdbus_engine.sv
module pdbus_engine
  import pdbus_pkg::*;
#(
  parameter int PIX_CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          cfg_edge_word,
  input  logic [31:0]          cfg_cycle_word,
  input  logic                 cfg_div2,
  input  logic [1:0]           cfg_width,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic [DBUS_W-1:0]    req_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DBUS_W-1:0]    rd_data,
  input  logic                 strm_start,
  input  logic [PIX_CNT_W-1:0] strm_count,
  output logic                 strm_active,
  output logic                 frame_done,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [DBUS_W-1:0]    pix_data,
  output logic                 busy,
  output logic                 cfg_err,
  output logic                 bus_cs_n,
  output logic                 bus_we_n,
  output logic                 bus_re_n,
  output logic                 bus_dc,
  output logic                 bus_oe,
  output logic [DBUS_W-1:0]    bus_dout,
  input  logic [DBUS_W-1:0]    bus_din
);
  localparam logic [DBUS_W-1:0] NARROW_MASK = DBUS_W'((1 << NARROW_W) - 1);

  pdbus_tim_t tim;
  logic wide, bad;
  logic tick, seq_active, seq_rd, last_tick, sample;
  logic launch, launch_rd, host_go, pix_go, idle;
  logic [DBUS_W-1:0] mask;

  pdbus_cfgchk u_cfg (
    .edge_word (cfg_edge_word),
    .cycle_word(cfg_cycle_word),
    .width_sel (cfg_width),
    .tim       (tim),
    .wide      (wide),
    .bad       (bad)
  );

  pdbus_tick u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (seq_active),
    .div2 (cfg_div2),
    .tick (tick)
  );

  pdbus_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .launch_rd(launch_rd),
    .tick     (tick),
    .tim      (tim),
    .active   (seq_active),
    .is_rd    (seq_rd),
    .last_tick(last_tick),
    .sample   (sample),
    .cs_n     (bus_cs_n),
    .we_n     (bus_we_n),
    .re_n     (bus_re_n)
  );

  logic                 strm_q, done_q, rdv_q, err_q, dc_q, oe_q;
  logic [PIX_CNT_W-1:0] remain_q;
  logic [DBUS_W-1:0]    dout_q, rdat_q;

  assign mask      = wide ? '1 : NARROW_MASK;
  assign idle      = !seq_active;
  assign req_ready = idle && !strm_q && !rdv_q;
  assign pix_ready = idle && strm_q && (remain_q != '0);
  assign host_go   = req_valid && req_ready;
  assign pix_go    = pix_valid && pix_ready;
  assign launch    = host_go || pix_go;
  assign launch_rd = host_go && req_kind[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q   <= 1'b0;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else if (launch) begin
      dc_q   <= pix_go || (req_kind != 2'b00);
      oe_q   <= !launch_rd;
      dout_q <= (pix_go ? pix_data : req_data) & mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      if (sample) rdat_q <= bus_din & mask;
      if (last_tick && seq_rd)      rdv_q <= 1'b1;
      else if (rdv_q && rd_ready)   rdv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strm_q   <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!strm_q && strm_start && idle && !rdv_q) begin
        if (strm_count == '0) done_q <= 1'b1;
        else begin
          strm_q   <= 1'b1;
          remain_q <= strm_count;
        end
      end else if (strm_q) begin
        if (pix_go) remain_q <= remain_q - 1'b1;
        if (last_tick && remain_q == '0) begin
          strm_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign busy        = seq_active;
  assign bus_dc      = dc_q;
  assign bus_oe      = seq_active && oe_q;
  assign bus_dout    = dout_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdat_q;
  assign strm_active = strm_q;
  assign frame_done  = done_q;
  assign cfg_err     = err_q;
endmodule

// File: rtl/pdbus_engine_chk.sv
module pdbus_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        req_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_data,
  input logic        strm_active,
  input logic        frame_done,
  input logic        cfg_err,
  input logic        bus_cs_n,
  input logic        bus_we_n,
  input logic        bus_re_n
);
  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cs_n && bus_we_n && bus_re_n));

  assert_ready_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !rd_valid));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !strm_active);

  assert_stream_blocks_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strm_active |-> !req_ready);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_re_n));
endmodule

bind pdbus_engine pdbus_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .strm_active(strm_active),
  .frame_done (frame_done),
  .cfg_err    (cfg_err),
  .bus_cs_n   (bus_cs_n),
  .bus_we_n   (bus_we_n),
  .bus_re_n   (bus_re_n)
);

// File: tb/tb_pdbus_engine.sv
`timescale 1ns/1ps
module tb_pdbus_engine;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_edge_word = '0, cfg_cycle_word = '0;
  logic cfg_div2 = 1'b0;
  logic [1:0] cfg_width = 2'b11;
  logic req_valid = 1'b0, rd_ready = 1'b0, strm_start = 1'b0, pix_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_data = '0, pix_data = '0, bus_din = '0;
  logic [CW-1:0] strm_count = '0;
  logic req_ready, rd_valid, strm_active, frame_done, pix_ready, busy, cfg_err;
  logic bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_oe;
  logic [15:0] rd_data, bus_dout;

  pdbus_engine #(.PIX_CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_edge_word(cfg_edge_word), .cfg_cycle_word(cfg_cycle_word),
    .cfg_div2(cfg_div2), .cfg_width(cfg_width), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_data(req_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .strm_start(strm_start), .strm_count(strm_count),
    .strm_active(strm_active), .frame_done(frame_done), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .busy(busy), .cfg_err(cfg_err),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_dc(bus_dc),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int c_on, c_off, w_on, w_off, r_on, r_off, w_len, r_len, a_t;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    cfg_edge_word  = c_on | (c_off << 4) | (w_on << 10) | (w_off << 14) | (r_on << 20) | (r_off << 24);
    cfg_cycle_word = w_len | (r_len << 6) | (a_t << 22);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_txn(input logic [1:0] kind, input logic [15:0] data);
    int dv, len, t, ex, mask;
    bit rd;
    string tag;
    rd   = kind[1];
    dv   = cfg_div2 ? 2 : 1;
    len  = rd ? r_len : w_len;
    if (len == 0) len = 1;
    mask = (cfg_width == 2'b11) ? 32'hFFFF : 32'h00FF;
    tag  = cfg_div2 ? "R5" : (rd ? "R4" : "R2");
    @(negedge clk);
    req_kind = kind; req_data = data; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int j = 0; j < len * dv; j++) begin
      @(negedge clk);
      req_valid = 1'b0;
      bus_din = 16'hC300 + 16'(j);
      t = j / dv;
      ex = {(t >= c_on && t < c_off) ? 1'b0 : 1'b1,
            (!rd && t >= w_on && t < w_off) ? 1'b0 : 1'b1,
            (rd && t >= r_on && t < r_off) ? 1'b0 : 1'b1, 1'b1};
      chk({tag, " strobes/busy"}, {bus_cs_n, bus_we_n, bus_re_n, busy}, ex);
      if (j == 0) begin
        chk("R3 dc", bus_dc, (kind == 2'b00) ? 0 : 1);
        chk("R3 oe", bus_oe, rd ? 0 : 1);
        chk("R7 ready low while busy", req_ready, 0);
        if (!rd) chk("R6 dout", bus_dout, data & mask);
      end
    end
    @(negedge clk);
    chk({tag, " cycle end"}, busy, 0);
    if (rd) begin
      chk("R4 rd_valid", rd_valid, 1);
      chk("R4 R6 rd_data", rd_data, (16'hC300 + a_t * dv + dv - 1) & mask);
      repeat (2) @(negedge clk);
      chk("R7 result held", {rd_valid, req_ready}, 2'b10);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk("R7 result taken", rd_valid, 0);
    end
  endtask

  task automatic run_frame(input int n);
    int sent = 0, nwe = 0, ndone = 0;
    bit acc = 0, prev_we = 1;
    @(negedge clk);
    strm_count = CW'(n); strm_start = 1'b1; pix_valid = 1'b0;
    @(negedge clk);
    strm_start = 1'b0;
    if (n == 0) begin
      chk("R8 zero count done", {frame_done, strm_active}, 2'b10);
      return;
    end
    chk("R8 active", strm_active, 1);
    req_valid = 1'b1; req_kind = 2'b00;
    chk("R9 host refused", req_ready, 0);
    @(negedge clk);
    chk("R9 no host cycle", {bus_cs_n, busy}, 2'b10);
    req_valid = 1'b0;
    pix_valid = 1'b1; pix_data = 16'h1000;
    for (int k = 0; k < 400 && ndone == 0; k++) begin
      acc = pix_valid && pix_ready;
      @(negedge clk);
      if (acc) sent++;
      pix_data = 16'h1000 + 16'(sent);
      if (prev_we && !bus_we_n) begin
        chk("R8 pixel order", bus_dout, 16'h1000 + nwe);
        chk("R8 pixel dc", bus_dc, 1);
        nwe++;
      end
      prev_we = bus_we_n;
      if (frame_done) ndone++;
    end
    pix_valid = 1'b0;
    chk("R8 pixel count", nwe, n);
    chk("R8 done seen", ndone, 1);
    chk("R8 active cleared", strm_active, 0);
    @(negedge clk);
    chk("R8 done single", frame_done, 0);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    c_on = 0; c_off = 2; w_on = 0; w_off = 1; r_on = 0; r_off = 1; w_len = 2; r_len = 2; a_t = 1;
    apply_cfg();
    do_reset();
    chk("R1 reset strobes", {bus_cs_n, bus_we_n, bus_re_n}, 3'b111);
    chk("R1 reset flags", {busy, rd_valid, strm_active, frame_done, cfg_err}, 0);
    chk("R1 reset ready", req_ready, 1);

    // write sweep
    for (int dv = 0; dv < 2; dv++)
      for (int co = 0; co < 2; co++)
        for (int wo = 0; wo < 3; wo++)
          for (int wl = 1; wl < 3; wl++)
            for (int ce = 0; ce < 2; ce++) begin
              @(negedge clk);
              cfg_div2 = dv[0];
              cfg_width = ce[0] ? 2'b00 : 2'b11;
              c_on = co; w_on = wo; w_off = wo + wl;
              c_off = ((w_off > co + 1) ? w_off : co + 1) + ce;
              w_len = c_off + ce;
              r_on = 0; r_off = 1; r_len = 1; a_t = 1;
              apply_cfg();
              run_txn(wo[0] ? 2'b01 : 2'b00, 16'hA55A ^ 16'(wo * 37 + co));
            end

    // read sweep
    for (int dv = 0; dv < 2; dv++)
      for (int ro = 0; ro < 3; ro++)
        for (int rl = 1; rl < 3; rl++)
          for (int ae = 1; ae < 3; ae++)
            for (int xe = 0; xe < 2; xe++) begin
              @(negedge clk);
              cfg_div2 = dv[0];
              cfg_width = xe[0] ? 2'b00 : 2'b11;
              c_on = 0; w_on = 0; w_off = 1; w_len = 2;
              r_on = ro; r_off = ro + rl; a_t = ro + ae;
              r_len = a_t + 1 + xe;
              c_off = r_off;
              apply_cfg();
              run_txn(2'b10, 16'h0);
            end
    chk("R10 valid configs leave flag clear", cfg_err, 0);

    // frames of several lengths
    @(negedge clk);
    cfg_div2 = 1'b0; cfg_width = 2'b11;
    c_on = 0; c_off = 2; w_on = 0; w_off = 1; w_len = 3; r_on = 0; r_off = 1; r_len = 1; a_t = 1;
    apply_cfg();
    for (int n = 0; n < 5; n++) run_frame(n);
    @(negedge clk); cfg_div2 = 1'b1;
    run_frame(3);

    // invalid ordering: strobes follow the counts, flag sticks
    @(negedge clk);
    cfg_div2 = 1'b0;
    c_on = 1; c_off = 3; w_on = 3; w_off = 1; w_len = 0;
    apply_cfg();
    @(negedge clk);
    chk("R10 flag on bad order", cfg_err, 1);
    run_txn(2'b01, 16'h1234);
    c_on = 0; c_off = 2; w_on = 0; w_off = 1; w_len = 2;
    apply_cfg();
    run_txn(2'b00, 16'h0042);
    chk("R10 flag sticky", cfg_err, 1);

    // reserved width codes
    do_reset();
    chk("R10 reset clears flag", cfg_err, 0);
    @(negedge clk); cfg_width = 2'b01;
    @(negedge clk);
    chk("R10 width 01", cfg_err, 1);
    do_reset();
    @(negedge clk); cfg_width = 2'b10;
    @(negedge clk);
    chk("R10 width 10", cfg_err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule